// File: doc/BRIEF.md
# Two-Wire Debug Link Mode Detector

This block watches the clock and data wires of a two-wire compact test link. Both wires are already synchronised into the system clock domain. From them it works out which mode the link is in: plain four-wire operation, reception of the activation code, or the scanning format with three slots per bit (OScan1).

An escape is a burst of data-wire transitions made while the link clock is held high. The block counts these transitions and acts on the count at the next rising edge of the link clock:
- Exactly six transitions start reception of the activation code.
- Eight or more transitions return the link to four-wire mode.

During activation, every rising link-clock edge advances a bit index. The data-wire value at bit 8 decides whether the code is 12 or 36 bits long. When the index passes that length, the link switches to OScan1. On that switch the block emits two one-cycle pulses: one forces the downstream test controller into its reset state, and one marks the mode change. The block also reports which field of the activation code the index is in. It does not check what those fields contain.

Top module: `twowire_mode_detect`

## Requirements
- R1: After reset, `linkMode` is 0 (four-wire), `actIndex` is 0, `actPhase` is 0, and both pulse outputs are low. The mode encoding is 0 for four-wire, 1 for activation and 2 for OScan1.
- R2: A data-wire change counts as an escape transition only when the link clock was high in both the previous and the current system cycle. Changes made while the link clock is low are never counted.
- R3: At a rising link-clock edge, an escape count of exactly 6 puts the link in activation mode (1). The index restarts from 0 and the length is set to 12. The same edge is the first activation bit, so `actIndex` reads 1 afterwards.
- R4: At a rising link-clock edge, an escape count of 8 or more sets the mode to four-wire (0), whatever the previous mode was.
- R5: Any other escape count (0 to 5, or 7) leaves the mode unchanged. Every rising link-clock edge clears the count, so transitions from separate high phases never add up.
- R6: In activation mode, each rising link-clock edge adds exactly 1 to `actIndex`. In the other modes `actIndex` holds its value.
- R7: If the data wire is 0 on the rising edge that brings the index to 8, the code length becomes 36. The index then passes the length on the 37th activation edge, counting the edge that ends the escape as the 1st.
- R8: When the index would go past the code length (13th edge for a 12-bit code), the mode becomes OScan1 (2). On that edge `tapResetPulse` and `oscanEntryPulse` are both high for exactly one system cycle.
- R9: In activation mode, `actPhase` is set from the index. It is 0 below index 5 and 1 from index 5 on. For a 12-bit code it is 9 from index 9 on. For a 36-bit code it is 2, 3, 4, 5, 6, 7, 8 and 9 from index 9, 14, 17, 19, 24, 26, 28 and 33 on. Outside activation it is 0.
- R10: The escape counter saturates at 15. Bursts of 16 or 22 transitions are therefore treated as 8 or more and select four-wire mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| tckcIn | input | 1 | Synchronised link clock |
| tmscIn | input | 1 | Synchronised link data |
| linkMode | output | 2 | 0 four-wire, 1 activation, 2 OScan1 |
| actIndex | output | IDX_W (6) | Activation bit index |
| actPhase | output | 4 | Activation field code (R9) |
| tapResetPulse | output | 1 | One-cycle reset request to downstream controller |
| oscanEntryPulse | output | 1 | One-cycle marker of OScan1 entry |

## Verification
The rising link-clock edge is detected from the raw input against its registered copy. Mode, index, phase and both pulses therefore change at the first system clock edge after `tckcIn` goes high. The bench samples them at the falling system edge that follows.

The escape count set up in one high phase only takes effect at the next rising edge. The bench's model therefore holds that count pending and applies it one link-clock edge later. It also checks at a later falling edge that each pulse has dropped after one cycle. Data-wire toggles are driven only after the link clock has been high for at least one system cycle, so each one is counted.

// File: rtl/twm_pkg.sv
package twm_pkg;

  typedef enum logic [1:0] {
    MODE_FOUR = 2'd0,
    MODE_ACT  = 2'd1,
    MODE_OSC  = 2'd2
  } linkMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic clrEsc;    // rising link clock: drop the escape count
    logic startAct;  // restart index and length
    logic stepIdx;   // advance activation index
  } ctrlStrobe_t;

  localparam int PHASE_W = 4;

endpackage

// File: rtl/twm_datapath.sv
module twm_datapath
  import twm_pkg::*;
#(
  parameter int ESC_W     = 4,
  parameter int SHORT_LEN = 12,
  parameter int LONG_LEN  = 36,
  parameter int EXT_IDX   = 8,
  parameter int EXT_FROM  = 5,
  parameter int IDX_W     = $clog2(LONG_LEN + 2)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               tckcIn,
  input  logic               tmscIn,
  input  ctrlStrobe_t        strobe,
  input  logic               actMode,
  output logic               riseEvt,
  output logic [ESC_W-1:0]   escCnt,
  output logic               overrun,
  output logic [IDX_W-1:0]   actIdx,
  output logic [PHASE_W-1:0] actPhase
);

  localparam int ESC_MAX = (1 << ESC_W) - 1;
  localparam int LONG_EDGE [8] = '{9, 14, 17, 19, 24, 26, 28, 33};

  logic             tckcQ;
  logic             tmscQ;
  logic             togEvt;
  logic             longSel;
  logic             longNext;
  logic [IDX_W-1:0] idxNext;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tckcQ <= 1'b0;
      tmscQ <= 1'b0;
    end else begin
      tckcQ <= tckcIn;
      tmscQ <= tmscIn;
    end
  end

  assign riseEvt = tckcIn & ~tckcQ;
  assign togEvt  = tckcIn & tckcQ & (tmscIn ^ tmscQ);

  // escape transition counter, saturating
  always_ff @(posedge clk) begin
    if (!rstN) begin
      escCnt <= '0;
    end else if (strobe.clrEsc) begin
      escCnt <= '0;
    end else if (togEvt && (escCnt != ESC_W'(ESC_MAX))) begin
      escCnt <= escCnt + 1'b1;
    end
  end

  // next index / length for the current rising edge
  always_comb begin
    idxNext  = (strobe.startAct ? '0 : actIdx) + 1'b1;
    longNext = strobe.startAct ? 1'b0 : longSel;
    if ((int'(idxNext) == EXT_IDX) && !tmscIn) longNext = 1'b1;
    overrun = strobe.stepIdx &&
              (int'(idxNext) > (longNext ? LONG_LEN : SHORT_LEN));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      actIdx  <= '0;
      longSel <= 1'b0;
    end else if (strobe.stepIdx) begin
      actIdx  <= idxNext;
      longSel <= longNext;
    end
  end

  // field decode by index
  always_comb begin
    actPhase = '0;
    if (actMode) begin
      if (int'(actIdx) >= EXT_FROM) actPhase = PHASE_W'(1);
      if (longSel) begin
        for (int k = 0; k < 8; k++) begin
          if (int'(actIdx) >= LONG_EDGE[k]) actPhase = PHASE_W'(k + 2);
        end
      end else if (int'(actIdx) > EXT_IDX) begin
        actPhase = PHASE_W'(9);
      end
    end
  end

  AST_ESC_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clrEsc |=> (escCnt == '0)); // R5

  AST_ESC_SATURATE: assert property (@(posedge clk) disable iff (!rstN)
    (escCnt == ESC_W'(ESC_MAX)) && !strobe.clrEsc |=> (escCnt == ESC_W'(ESC_MAX))); // R10

  AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.stepIdx |=> $stable(actIdx)); // R6

  AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    int'(actIdx) <= LONG_LEN + 1); // R8

  AST_LOW_CLOCK_NO_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    !tckcIn && !strobe.clrEsc |=> $stable(escCnt)); // R2

endmodule

// File: rtl/twm_control.sv
module twm_control
  import twm_pkg::*;
#(
  parameter int ESC_W    = 4,
  parameter int ESC_ACT  = 6,
  parameter int ESC_FOUR = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             riseEvt,
  input  logic [ESC_W-1:0] escCnt,
  input  logic             overrun,
  output ctrlStrobe_t      strobe,
  output linkMode_e        mode,
  output logic             tapRstPulse,
  output logic             oscPulse
);

  logic      escFour;
  logic      escAct;
  linkMode_e modeEval;

  assign escFour = escCnt >= ESC_W'(ESC_FOUR);
  assign escAct  = escCnt == ESC_W'(ESC_ACT);

  always_comb begin
    modeEval = mode;
    if (escFour)     modeEval = MODE_FOUR;
    else if (escAct) modeEval = MODE_ACT;
  end

  always_comb begin
    strobe.clrEsc   = riseEvt;
    strobe.startAct = riseEvt && escAct && !escFour;
    strobe.stepIdx  = riseEvt && (modeEval == MODE_ACT);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mode        <= MODE_FOUR;
      tapRstPulse <= 1'b0;
      oscPulse    <= 1'b0;
    end else begin
      tapRstPulse <= riseEvt && overrun;
      oscPulse    <= riseEvt && overrun;
      if (riseEvt) mode <= overrun ? MODE_OSC : modeEval;
    end
  end

  AST_FOUR_ON_LONG_ESC: assert property (@(posedge clk) disable iff (!rstN)
    riseEvt && (escCnt >= ESC_W'(ESC_FOUR)) |=> (mode == MODE_FOUR)); // R4

  AST_ACT_ON_SIX: assert property (@(posedge clk) disable iff (!rstN)
    riseEvt && (escCnt == ESC_W'(ESC_ACT)) |=> (mode == MODE_ACT)); // R3

  AST_PULSE_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    oscPulse |-> (mode == MODE_OSC) && ($past(mode) == MODE_ACT)); // R8

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    oscPulse |=> !oscPulse); // R8

  AST_PULSE_PAIR: assert property (@(posedge clk) disable iff (!rstN)
    tapRstPulse == oscPulse); // R8

  AST_MODE_AT_RISE_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    !riseEvt |=> $stable(mode)); // R5

endmodule

// File: rtl/twowire_mode_detect.sv
module twowire_mode_detect
  import twm_pkg::*;
#(
  parameter int ESC_W     = 4,
  parameter int ESC_ACT   = 6,
  parameter int ESC_FOUR  = 8,
  parameter int SHORT_LEN = 12,
  parameter int LONG_LEN  = 36,
  parameter int EXT_IDX   = 8,
  parameter int EXT_FROM  = 5,
  parameter int IDX_W     = $clog2(LONG_LEN + 2)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tckcIn,
  input  logic             tmscIn,
  output logic [1:0]       linkMode,
  output logic [IDX_W-1:0] actIndex,
  output logic [3:0]       actPhase,
  output logic             tapResetPulse,
  output logic             oscanEntryPulse
);

  ctrlStrobe_t        strobe;
  linkMode_e          mode;
  logic               riseEvt;
  logic               overrun;
  logic [ESC_W-1:0]   escCnt;
  logic [PHASE_W-1:0] phase;

  twm_datapath #(
    .ESC_W(ESC_W), .SHORT_LEN(SHORT_LEN), .LONG_LEN(LONG_LEN),
    .EXT_IDX(EXT_IDX), .EXT_FROM(EXT_FROM), .IDX_W(IDX_W)
  ) i_datapath (
    .clk(clk), .rstN(rstN), .tckcIn(tckcIn), .tmscIn(tmscIn),
    .strobe(strobe), .actMode(mode == MODE_ACT),
    .riseEvt(riseEvt), .escCnt(escCnt), .overrun(overrun),
    .actIdx(actIndex), .actPhase(phase)
  );

  twm_control #(
    .ESC_W(ESC_W), .ESC_ACT(ESC_ACT), .ESC_FOUR(ESC_FOUR)
  ) i_control (
    .clk(clk), .rstN(rstN), .riseEvt(riseEvt), .escCnt(escCnt),
    .overrun(overrun), .strobe(strobe), .mode(mode),
    .tapRstPulse(tapResetPulse), .oscPulse(oscanEntryPulse)
  );

  assign linkMode = mode;
  assign actPhase = phase;

endmodule

// File: tb/test_twowire_mode_detect.sv
module test_twowire_mode_detect;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tckc = 1'b0;
  logic       tmsc = 1'b0;
  logic [1:0] linkMode;
  logic [5:0] actIndex;
  logic [3:0] actPhase;
  logic       tapResetPulse;
  logic       oscanEntryPulse;

  int nChecks = 0;
  int nErr = 0;
  bit done = 0;

  // reference model state
  int mMode = 0;
  int mIdx = 0;
  bit mLong = 0;
  int mPend = 0;
  bit mPulse = 0;
  bit lastOscPulse = 0;

  always #5 clk = ~clk;

  twowire_mode_detect i_twowire_mode_detect (
    .clk(clk), .rstN(rstN), .tckcIn(tckc), .tmscIn(tmsc),
    .linkMode(linkMode), .actIndex(actIndex), .actPhase(actPhase),
    .tapResetPulse(tapResetPulse), .oscanEntryPulse(oscanEntryPulse)
  );

  task automatic check(input int act, input int exp, input string tag);
    nChecks++;
    if (act != exp) begin
      nErr++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int expPhase();
    int p = 0;
    if (mMode != 1) return 0;
    if (mIdx >= 5) p = 1;
    if (mLong) begin
      if (mIdx >= 9)  p = 2;
      if (mIdx >= 14) p = 3;
      if (mIdx >= 17) p = 4;
      if (mIdx >= 19) p = 5;
      if (mIdx >= 24) p = 6;
      if (mIdx >= 26) p = 7;
      if (mIdx >= 28) p = 8;
      if (mIdx >= 33) p = 9;
    end else if (mIdx >= 9) p = 9;
    return p;
  endfunction

  // apply one rising link-clock edge to the model (R3..R10)
  task automatic modelStep(input logic tms);
    int esc = (mPend > 15) ? 15 : mPend;
    mPulse = 0;
    if (esc >= 8) mMode = 0;
    else if (esc == 6) begin mMode = 1; mIdx = 0; mLong = 0; end
    if (mMode == 1) begin
      mIdx++;
      if (mIdx == 8 && tms == 1'b0) mLong = 1;
      if (mIdx > (mLong ? 36 : 12)) begin mMode = 2; mPulse = 1; end
    end
  endtask

  // one link-clock period: rise with data=tms, then 'toggles' escape transitions
  task automatic doRise(input logic tms, input int toggles, input string tag);
    @(negedge clk); tmsc = tms;
    @(negedge clk); tckc = 1'b1;
    @(negedge clk);
    modelStep(tms);
    check(int'(linkMode), mMode, tag);
    check(int'(actIndex), mIdx, "R6");
    check(int'(actPhase), expPhase(), "R9");
    check(int'(tapResetPulse), int'(mPulse), "R8");
    check(int'(oscanEntryPulse), int'(mPulse), "R8");
    lastOscPulse = oscanEntryPulse;
    for (int k = 0; k < toggles; k++) begin
      tmsc = ~tmsc;
      @(negedge clk);
    end
    mPend = toggles;
    tckc = 1'b0;
    @(negedge clk);
    check(int'(oscanEntryPulse), 0, "R8");
    check(int'(tapResetPulse), 0, "R8");
  endtask

  function automatic string tagFor(input int n);
    if (n >= 16) return "R10";
    if (n >= 8) return "R4";
    if (n == 6) return "R3";
    return "R5";
  endfunction

  initial begin
    #(10 * 150000);
    if (!done) begin
      nErr++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("  CHECKS %0d ERRORS %0d", nChecks, nErr);
      $finish;
    end
  end

  initial begin
    int firstOsc;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(int'(linkMode), 0, "R1");
    check(int'(actIndex), 0, "R1");
    check(int'(actPhase), 0, "R1");
    check(int'(tapResetPulse), 0, "R1");
    check(int'(oscanEntryPulse), 0, "R1");

    // R2: six toggles with link clock low are not an escape
    for (int k = 0; k < 6; k++) begin
      @(negedge clk); tmsc = ~tmsc;
    end
    doRise(1'b1, 0, "R2");

    // sweep of escape counts from four-wire mode
    for (int n = 0; n <= 22; n++) begin
      doRise(1'b1, n, "R5");
      doRise(1'b1, 0, tagFor(n));
      doRise(1'b1, 8, "R4");
      doRise(1'b1, 0, "R4");
    end

    // sweep of escape counts from activation mode
    for (int n = 0; n <= 22; n++) begin
      doRise(1'b1, 6, "R5");
      doRise(1'b1, n, "R3");
      doRise(1'b1, 0, tagFor(n));
      doRise(1'b1, 8, "R4");
      doRise(1'b1, 0, "R4");
    end

    // R5: 3 + 3 transitions across two high phases do not add up
    doRise(1'b1, 3, "R5");
    doRise(1'b1, 3, "R5");
    doRise(1'b1, 0, "R5");

    // R8: short code, data 1 at bit 8, OScan1 on the 13th edge
    doRise(1'b1, 6, "R5");
    firstOsc = 0;
    for (int k = 1; k <= 16; k++) begin
      doRise(1'b1, 0, "R3");
      if (lastOscPulse && firstOsc == 0) firstOsc = k;
    end
    check(firstOsc, 13, "R8");

    // R7: long code, data 0 at bit 8, OScan1 on the 37th edge
    doRise(1'b0, 6, "R5");
    firstOsc = 0;
    for (int k = 1; k <= 40; k++) begin
      doRise(1'b0, 0, "R7");
      if (lastOscPulse && firstOsc == 0) firstOsc = k;
    end
    check(firstOsc, 37, "R7");

    // from OScan1: 7 keeps it, 6 restarts activation, 8 returns to four-wire
    doRise(1'b1, 7, "R5");
    doRise(1'b1, 0, "R5");
    check(int'(linkMode), 2, "R5");
    doRise(1'b1, 6, "R5");
    doRise(1'b1, 0, "R3");
    check(int'(linkMode), 1, "R3");
    doRise(1'b1, 8, "R6");
    doRise(1'b1, 0, "R4");
    check(int'(linkMode), 0, "R4");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", nChecks, nErr);
    $finish;
  end

endmodule